// File: doc/BRIEF.md
# Multi-Channel Shared-Memory FIFO

This block holds several independent first-in first-out queues inside one dual-port memory. All of them run on a single clock. The memory is split into equal fixed regions, one region per channel. Writes always go through one memory port and reads through the other, so in any cycle the block accepts at most one push and one pop. The push and the pop may name the same channel or two different channels.

Each channel has a write pointer and a read pointer. Both are maximal-length LFSR sequences rather than binary counts, and neither ever holds the all-zero value. The memory address is the channel index placed above that channel's pointer. A separate binary up/down counter per channel holds its fill level, and the empty and full flags are decoded from that counter. When a request cannot be honoured (a push to a full channel or a pop from an empty one), the block drops it and sets an error bit for that channel. The error bit stays set until reset. A pop returns its data from a registered memory read, together with a valid strobe, in the cycle after the pop.

The channel count must be a power of two, at least 2. The pointer width must be between 2 and 8.

Top module: `mcFifoTop`

## Requirements
- R1: While reset is high and after it is released, every channel shows empty=1, full=0 and error=0, and popValid is 0. Reset is asynchronous and active high.
- R2: Each channel returns the words pushed to it in the order they were pushed. Traffic on one channel never changes the contents or flags of another channel.
- R3: An accepted pop at clock edge N puts the word on popData with popValid=1 after edge N, for exactly one cycle. In every cycle with no accepted pop, popValid is 0.
- R4: A channel holds 2^PTR_W-1 words (7 by default). Full is 1 exactly when the count equals that value, empty is 1 exactly when the count is zero, and no channel is ever empty and full at once.
- R5: A push to a full channel is dropped. The stored words and the full flag stay as they were, and that channel's error bit (bit index = channel number of errVec) becomes 1.
- R6: A pop from an empty channel is dropped. popValid stays 0 and that channel's error bit becomes 1.
- R7: Once an error bit is 1, it stays 1 until reset.
- R8: A push and a pop to the same non-empty, non-full channel in the same cycle are both accepted. The fill level does not change, and the popped word is the oldest stored word.
- R9: Whether a request is accepted depends only on the flags at the start of the cycle. A push to a full channel is dropped even when a pop to that channel is accepted in the same cycle. A pop from an empty channel is dropped even when a push to that channel is accepted in the same cycle.
- R10: Continuous traffic that runs far past the channel capacity (the pointers wrap round their LFSR cycle) still returns every word in order.
- R11: A push to one channel and a pop from another channel in the same cycle are both served, each as if it were alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both memory ports and all state |
| rst | input | 1 | Asynchronous active-high reset |
| pushEn | input | 1 | Push request |
| pushCh | input | $clog2(NUM_CH) | Channel targeted by the push |
| pushData | input | DATA_W | Word to store |
| popEn | input | 1 | Pop request |
| popCh | input | $clog2(NUM_CH) | Channel targeted by the pop |
| popData | output | DATA_W | Registered word from the last accepted pop |
| popValid | output | 1 | popData carries a popped word this cycle |
| emptyVec | output | NUM_CH | Per-channel empty flags |
| fullVec | output | NUM_CH | Per-channel full flags |
| errVec | output | NUM_CH | Per-channel sticky error flags |

## Verification
A push and a pop can be presented in the same cycle, and that is where the tests concentrate. The bench drives both requests on one channel in three states: partly filled, empty and full. In the partly filled case, the channel must drain exactly one word later. In the empty case, the push must land while the pop is dropped with an error. In the full case, the pop must be served while the push is dropped. The bench also sends a push and a pop to two different channels in the same cycle and checks that each channel's contents come out unaffected.

// File: rtl/mc_fifo_pkg.sv
package mc_fifo_pkg;
  // Strobes from the control to the storage datapath.
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } memStrobe_t;

  // Feedback taps for a maximal-length left-shifting LFSR of the given width.
  function automatic logic [7:0] lfsrTaps(input int width);
    case (width)
      2:       lfsrTaps = 8'b0000_0011;
      3:       lfsrTaps = 8'b0000_0110;
      4:       lfsrTaps = 8'b0000_1100;
      5:       lfsrTaps = 8'b0001_0100;
      6:       lfsrTaps = 8'b0011_0000;
      7:       lfsrTaps = 8'b0110_0000;
      default: lfsrTaps = 8'b1011_1000;
    endcase
  endfunction
endpackage

// File: rtl/mc_fifo_ctrl.sv
module mcFifoCtrl
  import mc_fifo_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 3,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pushEn,
  input  logic [CH_W-1:0]   pushCh,
  input  logic              popEn,
  input  logic [CH_W-1:0]   popCh,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [NUM_CH-1:0] emptyVec,
  output logic [NUM_CH-1:0] fullVec,
  output logic [NUM_CH-1:0] errVec
);
  localparam logic [PTR_W-1:0] TAPS     = PTR_W'(lfsrTaps(PTR_W));
  localparam logic [PTR_W-1:0] FULL_CNT = '1;
  localparam logic [PTR_W-1:0] SEED     = PTR_W'(1);

  logic [PTR_W-1:0] wrPtrQ [NUM_CH];
  logic [PTR_W-1:0] rdPtrQ [NUM_CH];
  logic [PTR_W-1:0] countQ [NUM_CH];
  logic             pushOk, popOk;

  // Acceptance is judged on the flags held at the start of the cycle.
  assign pushOk = pushEn && !fullVec[pushCh];
  assign popOk  = popEn && !emptyVec[popCh];

  assign strobe.wrEn = pushOk;
  assign strobe.rdEn = popOk;
  assign wrAddr = {pushCh, wrPtrQ[pushCh]};
  assign rdAddr = {popCh, rdPtrQ[popCh]};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic inc, dec, badPush, badPop;

    assign inc     = pushOk && (pushCh == CH_W'(ch));
    assign dec     = popOk && (popCh == CH_W'(ch));
    assign badPush = pushEn && !pushOk && (pushCh == CH_W'(ch));
    assign badPop  = popEn && !popOk && (popCh == CH_W'(ch));

    assign emptyVec[ch] = (countQ[ch] == '0);
    assign fullVec[ch]  = (countQ[ch] == FULL_CNT);

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        wrPtrQ[ch] <= SEED;
        rdPtrQ[ch] <= SEED;
        countQ[ch] <= '0;
        errVec[ch] <= 1'b0;
      end else begin
        if (inc) wrPtrQ[ch] <= {wrPtrQ[ch][PTR_W-2:0], ^(wrPtrQ[ch] & TAPS)};
        if (dec) rdPtrQ[ch] <= {rdPtrQ[ch][PTR_W-2:0], ^(rdPtrQ[ch] & TAPS)};
        if (inc && !dec)      countQ[ch] <= countQ[ch] + 1'b1;
        else if (dec && !inc) countQ[ch] <= countQ[ch] - 1'b1;
        if (badPush || badPop) errVec[ch] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mc_fifo_dpath.sv
module mcFifoDpath
  import mc_fifo_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Write port.
  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrAddr] <= wrData;
  end

  // Read port with a registered output.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= mem[rdAddr];
    end
  end
endmodule

// File: rtl/mc_fifo_top.sv
module mcFifoTop
  import mc_fifo_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 3,
  parameter int DATA_W = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pushEn,
  input  logic [CH_W-1:0]   pushCh,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  input  logic [CH_W-1:0]   popCh,
  output logic [DATA_W-1:0] popData,
  output logic              popValid,
  output logic [NUM_CH-1:0] emptyVec,
  output logic [NUM_CH-1:0] fullVec,
  output logic [NUM_CH-1:0] errVec
);
  memStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  mcFifoCtrl #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .pushEn(pushEn), .pushCh(pushCh),
    .popEn(popEn), .popCh(popCh),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyVec(emptyVec), .fullVec(fullVec), .errVec(errVec)
  );

  mcFifoDpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .wrAddr(wrAddr), .wrData(pushData),
    .rdAddr(rdAddr), .rdData(popData), .rdValid(popValid)
  );
endmodule

// File: rtl/mc_fifo_checker.sv
module mcFifoChecker #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              pushEn,
  input logic [CH_W-1:0]   pushCh,
  input logic              popEn,
  input logic [CH_W-1:0]   popCh,
  input logic              popValid,
  input logic [NUM_CH-1:0] emptyVec,
  input logic [NUM_CH-1:0] fullVec,
  input logic [NUM_CH-1:0] errVec
);
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    (emptyVec & fullVec) == '0);

  p_pop_served_r3: assert property (@(posedge clk) disable iff (rst)
    popEn && !emptyVec[popCh] |=> popValid);

  p_no_pop_r3: assert property (@(posedge clk) disable iff (rst)
    !popEn |=> !popValid);

  p_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
    popEn && emptyVec[popCh] |=> !popValid && errVec[$past(popCh)]);

  p_full_kept_r5: assert property (@(posedge clk) disable iff (rst)
    pushEn && fullVec[pushCh] && !(popEn && popCh == pushCh)
    |=> fullVec[$past(pushCh)] && errVec[$past(pushCh)]);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (errVec & $past(errVec)) == $past(errVec));
endmodule

bind mcFifoTop mcFifoChecker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .pushEn(pushEn), .pushCh(pushCh),
  .popEn(popEn), .popCh(popCh), .popValid(popValid),
  .emptyVec(emptyVec), .fullVec(fullVec), .errVec(errVec)
);

// File: tb/mc_fifo_bench.sv
module mcFifoTop_bench;
  localparam int NUM_CH = 8;
  localparam int PTR_W  = 3;
  localparam int DATA_W = 8;
  localparam int CH_W   = 3;
  localparam int CAP    = (1 << PTR_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pushEn = 1'b0;
  logic [CH_W-1:0]   pushCh = '0;
  logic [DATA_W-1:0] pushData = '0;
  logic              popEn = 1'b0;
  logic [CH_W-1:0]   popCh = '0;
  logic [DATA_W-1:0] popData;
  logic              popValid;
  logic [NUM_CH-1:0] emptyVec, fullVec, errVec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mcFifoTop #(.NUM_CH(NUM_CH), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_mcFifoTop (
    .clk(clk), .rst(rst), .pushEn(pushEn), .pushCh(pushCh), .pushData(pushData),
    .popEn(popEn), .popCh(popCh), .popData(popData), .popValid(popValid),
    .emptyVec(emptyVec), .fullVec(fullVec), .errVec(errVec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock with the given requests; outputs are sampled just after the edge.
  task automatic op(input logic pe, input int pc, input logic [DATA_W-1:0] pd,
                    input logic oe, input int oc);
    @(negedge clk);
    pushEn = pe; pushCh = CH_W'(pc); pushData = pd;
    popEn = oe; popCh = CH_W'(oc);
    @(posedge clk); #1;
    pushEn = 1'b0; popEn = 1'b0;
  endtask

  task automatic push(input int ch, input logic [DATA_W-1:0] d);
    op(1'b1, ch, d, 1'b0, 0);
  endtask

  task automatic popExpect(input string req, input int ch, input logic [DATA_W-1:0] d);
    op(1'b0, 0, '0, 1'b1, ch);
    chk({req, " valid"}, 32'(popValid), 32'd1);
    chk({req, " data"}, 32'(popData), 32'(d));
  endtask

  task automatic t_reset();
    chk("R1 empty", 32'(emptyVec), 32'hFF);
    chk("R1 full", 32'(fullVec), 32'h0);
    chk("R1 err", 32'(errVec), 32'h0);
    chk("R1 valid", 32'(popValid), 32'h0);
  endtask

  task automatic t_order();
    push(0, 8'h11); push(0, 8'h22); push(0, 8'h33);
    chk("R3 no pop no valid", 32'(popValid), 32'h0);
    chk("R2 other channels empty", 32'(emptyVec), 32'hFE);
    popExpect("R2 order", 0, 8'h11);
    popExpect("R2 order", 0, 8'h22);
    popExpect("R2 order", 0, 8'h33);
    chk("R4 empty after drain", 32'(emptyVec[0]), 32'd1);
  endtask

  task automatic t_independent();
    push(3, 8'hA0); push(5, 8'hB0); push(3, 8'hA1); push(5, 8'hB1);
    popExpect("R2 ch5", 5, 8'hB0);
    popExpect("R2 ch3", 3, 8'hA0);
    popExpect("R2 ch5", 5, 8'hB1);
    popExpect("R2 ch3", 3, 8'hA1);
    chk("R2 all empty", 32'(emptyVec), 32'hFF);
  endtask

  task automatic t_full();
    for (int i = 0; i < CAP - 1; i++) push(2, 8'(8'h40 + i));
    chk("R4 not full at cap-1", 32'(fullVec[2]), 32'd0);
    push(2, 8'(8'h40 + CAP - 1));
    chk("R4 full at cap", 32'(fullVec[2]), 32'd1);
    chk("R5 no err yet", 32'(errVec[2]), 32'd0);
    push(2, 8'hEE);
    chk("R5 err on full push", 32'(errVec), 32'h04);
    chk("R5 still full", 32'(fullVec), 32'h04);
    // Push and pop together on a full channel: pop served, push dropped.
    op(1'b1, 2, 8'hED, 1'b1, 2);
    chk("R9 pop served on full", 32'(popValid), 32'd1);
    chk("R9 pop data", 32'(popData), 32'h40);
    chk("R9 full cleared", 32'(fullVec[2]), 32'd0);
    for (int i = 1; i < CAP; i++) popExpect("R5 contents kept", 2, 8'(8'h40 + i));
    chk("R9 dropped push absent", 32'(emptyVec[2]), 32'd1);
  endtask

  task automatic t_pop_empty();
    op(1'b0, 0, '0, 1'b1, 6);
    chk("R6 no valid", 32'(popValid), 32'd0);
    chk("R6 err set", 32'(errVec[6]), 32'd1);
    push(6, 8'h66);
    popExpect("R7 after err", 6, 8'h66);
    chk("R7 sticky", 32'(errVec), 32'h44);
  endtask

  task automatic t_same_cycle();
    push(4, 8'hC1);
    op(1'b1, 4, 8'hC2, 1'b1, 4);
    chk("R8 pop valid", 32'(popValid), 32'd1);
    chk("R8 oldest", 32'(popData), 32'hC1);
    chk("R8 not empty", 32'(emptyVec[4]), 32'd0);
    popExpect("R8 second word", 4, 8'hC2);
    chk("R8 level kept", 32'(emptyVec[4]), 32'd1);
    // Push and pop together on an empty channel.
    op(1'b1, 7, 8'hD7, 1'b1, 7);
    chk("R9 pop dropped", 32'(popValid), 32'd0);
    chk("R9 err on empty pop", 32'(errVec[7]), 32'd1);
    chk("R9 push landed", 32'(emptyVec[7]), 32'd0);
    popExpect("R9 word", 7, 8'hD7);
  endtask

  task automatic t_cross();
    push(1, 8'h91);
    op(1'b1, 0, 8'h50, 1'b1, 1);
    chk("R11 pop other ch", 32'(popData), 32'h91);
    chk("R11 valid", 32'(popValid), 32'd1);
    chk("R11 flags", 32'(emptyVec), 32'hFE);
    popExpect("R11 push other ch", 0, 8'h50);
  endtask

  task automatic t_wrap();
    push(1, 8'h00);
    for (int i = 1; i < 24; i++) begin
      op(1'b1, 1, 8'(i), 1'b1, 1);
      chk("R10 wrap data", 32'(popData), 32'(8'(i - 1)));
    end
    popExpect("R10 wrap last", 1, 8'd23);
    chk("R10 empty", 32'(emptyVec[1]), 32'd1);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    t_reset();
    t_order();
    t_independent();
    t_full();
    t_pop_empty();
    t_same_cycle();
    t_cross();
    t_wrap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule